// File: doc/BRIEF.md
# Configurable Macrocell Storage Cell

This block is the storage element of one programmable-logic macrocell. A set of static configuration inputs turns it into a D-type register, a T-type register or a transparent D latch. The same inputs pick where its clock comes from, the polarity of that clock and of the data terms, and the value the cell holds when it comes out of reset. An exclusive-OR stage in front of the storage element lets a register cell behave as a J-K or S-R flip-flop, driven by two input terms.

The design is fully synchronous. Every clock source of the emulated cell (the shared block clocks and the per-cell product-term clock) is treated as a data signal. That signal is sampled by one fast system clock `clk`, and its active edge or active level is detected from the samples. In synchronous clocking mode, a select field picks one of the shared block clocks, and two block-wide terms can force the cell to 0 or to 1. In asynchronous clocking mode, the individual product-term clock drives the cell and the block-wide force terms are not used.

Top module: `mcell_store`

## Requirements
- R1: While `rst_n` is low, `q` equals `cfg_pwr_set` (0 gives a reset state, 1 gives a preset state). After release, the first active edge needs the effective clock to be sampled inactive and then active.
- R2: With `cfg_async`=0, the clock source is `blk_clk[cfg_clk_sel]`. Transitions on the other block clocks have no effect on `q`.
- R3: With `cfg_async`=1, the clock source is `pt_clk`, and `blk_clk` has no effect on `q`.
- R4: `cfg_clk_inv`=1 inverts the clock source. A falling raw transition then becomes the active edge, and a low raw level becomes the active latch level.
- R5: With `cfg_kind`=00 (or the reserved code 11), the cell is a D register. `q` takes the data term at the system edge where the clock source is first sampled active. It holds on the inactive transition and on any steady level.
- R6: With `cfg_kind`=01, the cell is a T register. `q` inverts on an active edge when the toggle term is 1 and holds when it is 0.
- R7: With `cfg_kind`=10, the cell is a latch. `q` follows `term_a` at every system edge where the enable is at its active level, and holds otherwise. `cfg_emul` has no effect in this kind.
- R8: `cfg_in_inv`=1 inverts both `term_a` and `term_b` before they are used.
- R9: With `cfg_emul`=01 in a register kind, `term_a` is J and `term_b` is K. On an active edge: J=1,K=1 toggles; J=1,K=0 sets; J=0,K=1 clears; J=0,K=0 holds.
- R10: With `cfg_emul`=10 in a register kind, `term_a` is S and `term_b` is R. On an active edge: S alone sets, R alone clears, and both or neither hold. Code 11 acts as 00, which is plain data.
- R11: With `cfg_async`=0, `blk_rst` forces `q` to 0 and `blk_pre` forces `q` to 1 at each system edge where they are high, overriding any storage action. `blk_rst` wins when both are high.
- R12: With `cfg_async`=1, `blk_rst` and `blk_pre` have no effect on `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every clock source |
| rst_n | input | 1 | Active-low power-up reset |
| cfg_kind | input | 2 | Storage kind: 00 D register, 01 T register, 10 latch, 11 as 00 |
| cfg_async | input | 1 | 0 selects a block clock, 1 selects the product-term clock |
| cfg_clk_sel | input | SEL_W | Block clock index in synchronous mode |
| cfg_clk_inv | input | 1 | Inverts the selected clock or enable |
| cfg_in_inv | input | 1 | Inverts both input terms |
| cfg_emul | input | 2 | 00 plain, 01 J-K, 10 S-R, 11 plain |
| cfg_pwr_set | input | 1 | Value loaded into q during reset |
| blk_clk | input | NUM_BLK_CLK | Shared block clocks |
| pt_clk | input | 1 | Individual product-term clock |
| term_a | input | 1 | D, T, J or S term |
| term_b | input | 1 | K or R term |
| blk_rst | input | 1 | Block-wide force-to-0 term |
| blk_pre | input | 1 | Block-wide force-to-1 term |
| q | output | 1 | Stored value |

## Verification
The bench builds the cell with four block clocks, no extra sampling stages and the emulation stage present. With these values the clock select has to tell one block clock from its neighbours, and every J-K and S-R row can be reached in both register kinds. Having no sampling stages means each active edge shows up on `q` at the very system edge that first sees it. That lets the scoreboard predict every value exactly, including the clock polarity flips: these are made while the source sits at a level where the flip creates no false edge.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

   typedef enum logic [1:0] {
      KIND_DREG  = 2'b00,
      KIND_TREG  = 2'b01,
      KIND_LATCH = 2'b10,
      KIND_RSVD  = 2'b11
   } store_kind_e;

   typedef enum logic [1:0] {
      EMUL_PLAIN = 2'b00,
      EMUL_JK    = 2'b01,
      EMUL_SR    = 2'b10,
      EMUL_RSVD  = 2'b11
   } emul_mode_e;

   function automatic int sel_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/mcell_clk_pick.sv
module mcell_clk_pick
   import mcell_pkg::*;
#(
   parameter int NUM_BLK_CLK = 4,
   parameter int SYNC_STAGES = 0,
   localparam int SEL_W = sel_width(NUM_BLK_CLK)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_async,
   input  logic [SEL_W-1:0]       cfg_clk_sel,
   input  logic                   cfg_clk_inv,
   input  logic [NUM_BLK_CLK-1:0] blk_clk,
   input  logic                   pt_clk,
   output logic                   src_edge,
   output logic                   src_level
);

   initial begin
      if (NUM_BLK_CLK < 1) $error("NUM_BLK_CLK must be at least 1");
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) $error("SYNC_STAGES must be 0 to 4");
   end

   logic blk_pick;
   logic raw_src;
   logic eff_src;
   logic smp_src;
   logic prev_src;

   always_comb begin
      blk_pick = blk_clk[0];
      for (int i = 0; i < NUM_BLK_CLK; i++) begin
         if (cfg_clk_sel == SEL_W'(i)) blk_pick = blk_clk[i];
      end
   end

   assign raw_src = cfg_async ? pt_clk : blk_pick;
   assign eff_src = raw_src ^ cfg_clk_inv;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign smp_src = eff_src;
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[SYNC_STAGES-2+1-1:0], eff_src} >> 0;
         end
         assign smp_src = chain[SYNC_STAGES-1];
      end
   endgenerate

   // previous sample starts at 1 so no edge is seen right after reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_src <= 1'b1;
      else        prev_src <= smp_src;
   end

   assign src_edge  = smp_src & ~prev_src;
   assign src_level = smp_src;

   // two active edges can never be seen on consecutive samples
   assert_edge_spaced_R2: assert property (@(posedge clk) disable iff (!rst_n)
      src_edge |=> !src_edge);

endmodule

// File: rtl/mcell_next.sv
module mcell_next
   import mcell_pkg::*;
#(
   parameter bit HAS_EMUL = 1'b1
) (
   input  logic [1:0] cfg_kind,
   input  logic [1:0] cfg_emul,
   input  logic       cfg_in_inv,
   input  logic       term_a,
   input  logic       term_b,
   input  logic       q_cur,
   input  logic       src_edge,
   input  logic       src_level,
   output logic       q_nxt,
   output logic       q_load
);

   logic a_pol;
   logic b_pol;
   logic plain_flip;
   logic flip;
   logic is_treg;
   logic is_latch;

   assign a_pol    = term_a ^ cfg_in_inv;
   assign b_pol    = term_b ^ cfg_in_inv;
   assign is_treg  = (cfg_kind == KIND_TREG);
   assign is_latch = (cfg_kind == KIND_LATCH);

   // a T register flips on the term; a D register flips when the term differs from q
   assign plain_flip = is_treg ? a_pol : (a_pol ^ q_cur);

   generate
      if (HAS_EMUL) begin : g_emul
         always_comb begin
            unique case (emul_mode_e'(cfg_emul))
               EMUL_JK: flip = (a_pol & ~q_cur) | (b_pol & q_cur);
               EMUL_SR: flip = (a_pol & ~b_pol & ~q_cur) | (b_pol & ~a_pol & q_cur);
               default: flip = plain_flip;
            endcase
         end
      end else begin : g_plain
         logic unused_b;
         assign unused_b = b_pol ^ cfg_emul[0] ^ cfg_emul[1];
         assign flip     = plain_flip;
      end
   endgenerate

   always_comb begin
      if (is_latch) begin
         q_nxt  = a_pol;
         q_load = src_level;
      end else begin
         q_nxt  = q_cur ^ flip;
         q_load = src_edge;
      end
   end

endmodule

// File: rtl/mcell_store.sv
module mcell_store
   import mcell_pkg::*;
#(
   parameter int NUM_BLK_CLK = 4,
   parameter int SYNC_STAGES = 0,
   parameter bit HAS_EMUL    = 1'b1,
   localparam int SEL_W      = sel_width(NUM_BLK_CLK)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             cfg_kind,
   input  logic                   cfg_async,
   input  logic [SEL_W-1:0]       cfg_clk_sel,
   input  logic                   cfg_clk_inv,
   input  logic                   cfg_in_inv,
   input  logic [1:0]             cfg_emul,
   input  logic                   cfg_pwr_set,
   input  logic [NUM_BLK_CLK-1:0] blk_clk,
   input  logic                   pt_clk,
   input  logic                   term_a,
   input  logic                   term_b,
   input  logic                   blk_rst,
   input  logic                   blk_pre,
   output logic                   q
);

   logic src_edge;
   logic src_level;
   logic q_nxt;
   logic q_load;
   logic force_lo;
   logic force_hi;

   mcell_clk_pick #(
      .NUM_BLK_CLK (NUM_BLK_CLK),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_clk_pick (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_async   (cfg_async),
      .cfg_clk_sel (cfg_clk_sel),
      .cfg_clk_inv (cfg_clk_inv),
      .blk_clk     (blk_clk),
      .pt_clk      (pt_clk),
      .src_edge    (src_edge),
      .src_level   (src_level)
   );

   mcell_next #(
      .HAS_EMUL (HAS_EMUL)
   ) u_next (
      .cfg_kind   (cfg_kind),
      .cfg_emul   (cfg_emul),
      .cfg_in_inv (cfg_in_inv),
      .term_a     (term_a),
      .term_b     (term_b),
      .q_cur      (q),
      .src_edge   (src_edge),
      .src_level  (src_level),
      .q_nxt      (q_nxt),
      .q_load     (q_load)
   );

   // block-wide force terms act only when a block clock drives the cell
   assign force_lo = ~cfg_async & blk_rst;
   assign force_hi = ~cfg_async & blk_pre;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= cfg_pwr_set;
      else if (force_lo) q <= 1'b0;
      else if (force_hi) q <= 1'b1;
      else if (q_load)   q <= q_nxt;
   end

   assert_rst_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_async && blk_rst) |=> !q);

   assert_pre_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_async && blk_pre && !blk_rst) |=> q);

   assert_dreg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_kind == KIND_DREG || cfg_kind == KIND_RSVD) && !src_edge
       && !(!cfg_async && (blk_rst || blk_pre))) |=> $stable(q));

   assert_treg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_kind == KIND_TREG && cfg_emul == EMUL_PLAIN && !(term_a ^ cfg_in_inv)
       && !(!cfg_async && (blk_rst || blk_pre))) |=> $stable(q));

   assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_kind == KIND_LATCH && !src_level
       && !(!cfg_async && (blk_rst || blk_pre))) |=> $stable(q));

endmodule

// File: tb/mcell_store_bench.sv
module mcell_store_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NBC        = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [1:0]     kind = 2'b00;
   logic           async_m = 1'b0;
   logic [1:0]     sel = 2'd2;
   logic           cinv = 1'b0;
   logic           iinv = 1'b0;
   logic [1:0]     emul = 2'b00;
   logic           pset = 1'b0;
   logic [NBC-1:0] bclk = '0;
   logic           ptc = 1'b0;
   logic           a = 1'b0;
   logic           b = 1'b0;
   logic           brst = 1'b0;
   logic           bpre = 1'b0;
   logic           q;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   typedef struct {
      logic  exp;
      string tag;
   } exp_t;
   exp_t sbq[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   mcell_store #(
      .NUM_BLK_CLK (NBC),
      .SYNC_STAGES (0),
      .HAS_EMUL    (1'b1)
   ) u_mcell_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_kind    (kind),
      .cfg_async   (async_m),
      .cfg_clk_sel (sel),
      .cfg_clk_inv (cinv),
      .cfg_in_inv  (iinv),
      .cfg_emul    (emul),
      .cfg_pwr_set (pset),
      .blk_clk     (bclk),
      .pt_clk      (ptc),
      .term_a      (a),
      .term_b      (b),
      .blk_rst     (brst),
      .blk_pre     (bpre),
      .q           (q)
   );

   // monitor: compares each queued expectation away from the active edge
   always @(negedge clk) begin
      while (sbq.size() > 0) begin
         exp_t it;
         it = sbq.pop_front();
         n_tests++;
         if (q !== it.exp) begin
            n_fail++;
            $display("FAIL %s: q=%b expected %b at %0t", it.tag, q, it.exp, $time);
         end
      end
   end

   // driver: one system edge, then queue the value q must show after it
   task automatic tick(input logic e, input string tag);
      exp_t it;
      @(posedge clk);
      #1;
      it.exp = e;
      it.tag = tag;
      sbq.push_back(it);
      @(negedge clk);
   endtask

   task automatic psync(input logic e, input string tag);
      bclk = 4'b0100;
      tick(e, tag);
      bclk = '0;
      tick(e, tag);
   endtask

   task automatic pasync(input logic e, input string tag);
      ptc = 1'b1;
      tick(e, tag);
      ptc = 1'b0;
      tick(e, tag);
   endtask

   task automatic wrap_up();
      @(negedge clk);
      #1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: run did not complete");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      // R1: power-up value
      pset = 1'b1; tick(1'b1, "R1 preset state");
      pset = 1'b0; tick(1'b0, "R1 reset state");
      rst_n = 1'b1; a = 1'b1; tick(1'b0, "R5 no edge after release");

      // R5 / R2: D register on block clock 2
      bclk = 4'b0100; tick(1'b1, "R5 load on active edge");
      a = 1'b0;       tick(1'b1, "R5 hold on high level");
      bclk = '0;      tick(1'b1, "R5 hold on inactive edge");
      bclk = 4'b1011; tick(1'b1, "R2 other block clocks ignored");
      bclk = '0;      tick(1'b1, "R2 other block clocks ignored");
      bclk = 4'b0100; tick(1'b0, "R5 load zero");

      // R4: inverted polarity, flipped while raw clock is high
      cinv = 1'b1;             tick(1'b0, "R4 polarity flip no edge");
      a = 1'b1; bclk = '0;     tick(1'b1, "R4 falling raw is active");
      a = 1'b0; bclk = 4'b0100; tick(1'b1, "R4 rising raw inactive");
      bclk = '0;               tick(1'b0, "R4 falling raw loads");
      cinv = 1'b0;             tick(1'b0, "R4 restore polarity");

      // R6: T register
      kind = 2'b01; a = 1'b1;
      psync(1'b1, "R6 toggle up");
      psync(1'b0, "R6 toggle down");
      a = 1'b0;
      psync(1'b0, "R6 hold with T=0");

      // R8: input inversion
      iinv = 1'b1;
      psync(1'b1, "R8 inverted term toggles");
      iinv = 1'b0;

      // R9: J-K emulation
      kind = 2'b00; emul = 2'b01;
      a = 1'b0; b = 1'b0; psync(1'b1, "R9 JK hold");
      a = 1'b0; b = 1'b1; psync(1'b0, "R9 JK clear");
      a = 1'b1; b = 1'b0; psync(1'b1, "R9 JK set");
      a = 1'b1; b = 1'b1; psync(1'b0, "R9 JK toggle");
      psync(1'b1, "R9 JK toggle again");
      kind = 2'b01; psync(1'b0, "R9 JK toggle in T kind");
      kind = 2'b00;

      // R10: S-R emulation
      emul = 2'b10;
      a = 1'b1; b = 1'b0; psync(1'b1, "R10 SR set");
      a = 1'b0; b = 1'b1; psync(1'b0, "R10 SR clear");
      a = 1'b1; b = 1'b1; psync(1'b0, "R10 SR both hold low");
      a = 1'b1; b = 1'b0; psync(1'b1, "R10 SR set again");
      a = 1'b1; b = 1'b1; psync(1'b1, "R10 SR both hold high");
      a = 1'b0; b = 1'b0; psync(1'b1, "R10 SR neither holds");
      emul = 2'b00;

      // R7: latch
      kind = 2'b10;
      tick(1'b1, "R7 closed latch holds");
      bclk = 4'b0100; tick(1'b0, "R7 open latch follows");
      a = 1'b1;       tick(1'b1, "R7 follows rise");
      a = 1'b0;       tick(1'b0, "R7 follows fall");
      a = 1'b1;       tick(1'b1, "R7 follows rise again");
      bclk = '0;      tick(1'b1, "R7 closes");
      a = 1'b0;       tick(1'b1, "R7 closed ignores data");
      emul = 2'b01; b = 1'b0;
      bclk = 4'b0100; tick(1'b0, "R7 emulation ignored in latch");
      bclk = '0;      tick(1'b0, "R7 closed");
      emul = 2'b00; kind = 2'b00;

      // R11: block force terms
      brst = 1'b1;              tick(1'b0, "R11 reset term");
      brst = 1'b0; bpre = 1'b1; tick(1'b1, "R11 preset term");
      brst = 1'b1;              tick(1'b0, "R11 reset wins");
      brst = 1'b0;              tick(1'b1, "R11 preset alone");
      bpre = 1'b0;              tick(1'b1, "R11 released holds");
      bpre = 1'b1; bclk = 4'b0100; tick(1'b1, "R11 preset beats edge");
      bpre = 1'b0; bclk = '0;      tick(1'b1, "R11 released");

      // R3 / R12: asynchronous mode
      async_m = 1'b1; a = 1'b0;
      bclk = 4'b0100; tick(1'b1, "R3 block clock ignored");
      bclk = '0;      tick(1'b1, "R3 block clock ignored");
      pasync(1'b0, "R3 product-term clock loads");
      a = 1'b1; pasync(1'b1, "R3 product-term clock loads one");
      brst = 1'b1; tick(1'b1, "R12 reset term ignored");
      brst = 1'b0;
      a = 1'b0; pasync(1'b0, "R3 load zero");
      bpre = 1'b1; tick(1'b0, "R12 preset term ignored");
      bpre = 1'b0;
      a = 1'b1; ptc = 1'b1; tick(1'b1, "R3 load one");
      cinv = 1'b1;           tick(1'b1, "R4 async polarity flip");
      a = 1'b0; ptc = 1'b0;  tick(1'b0, "R4 async falling active");
      a = 1'b1; ptc = 1'b1;  tick(1'b0, "R4 async rising inactive");

      // R1: second power-up, preset value and first edge after release
      rst_n = 1'b0; pset = 1'b1; tick(1'b1, "R1 preset on reset");
      rst_n = 1'b1;              tick(1'b1, "R1 no edge at release");
      a = 1'b0; ptc = 1'b0;      tick(1'b0, "R1 first active edge");

      done = 1'b1;
      wrap_up();
   end

endmodule